// File: doc/BRIEF.md
# Control-Flow Signature Checker Watchdog

This block sits beside a processor and watches its memory bus without taking part in any transfer. From the instruction fetches it keeps a running XOR of the words fetched in the current basic block. Two marker instructions drive it. The clear marker empties the accumulator. The compare marker captures the accumulator, and the next data write on the bus must carry that same value. The program can also write a block identifier and then a control-flow identifier to two snooped addresses. An iterative divider then checks that the block identifier divides the control-flow identifier exactly. Because identifiers are primes and a control-flow identifier is the product of the identifiers of the legal successor blocks, a nonzero remainder shows a jump that was not allowed.

A watchdog counts the run time from reset and flags an overrun. It also flags any bus access to the unused address range. A write to a dedicated address reports a data error that software itself detected. All findings go to one registered status word. The first error or the end-of-program write closes the run, and from then on the word is frozen until reset.

Top module: `cfsig_monitor`

## Requirements
- R1: After reset the whole status word reads zero.
- R2: Each instruction fetch that is not a marker is XORed into the signature. The compare marker captures the signature, and the next data write must carry exactly that value. Any other value sets status bit 2 (control-flow error) one cycle after the write.
- R3: A clear marker fetch sets the signature to zero, so any fetch before it has no effect on later comparisons.
- R4: A fetch is a marker when its top OPW data bits equal RST_OP (clear, default 0x3A) or CHK_OP (compare, default 0x3B). Marker words are never XORed into the signature.
- R5: A data write to CFID_ADDR starts a restoring division of the written value by the last value written to BID_ADDR. A nonzero remainder, or a block identifier of zero, sets status bit 2 within DW+2 cycles of the write. An exact division sets nothing.
- R6: A write to CFID_ADDR while a division is still running is ignored.
- R7: If the run is still open WDT_LIMIT cycles after reset, status bit 0 (watchdog) is set at that cycle and not before.
- R8: Any bus access (fetch, read or write) to an address at or above USED_LIMIT sets status bit 0 one cycle later.
- R9: A data write of any value to SWERR_ADDR sets status bit 1 (software data error) one cycle later.
- R10: Status bit 3 is set together with the first error, or by a data write to END_ADDR, whichever comes first. After that the status word does not change until reset.
- R11: Status bits [UPW+3:4] read zero while the run is open. They become all ones when the run ends with no error. Otherwise they hold the low UPW bits of the address of the last instruction fetch completed before the cycle in which the error was recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus transfer takes place this cycle |
| bus_write | input | 1 | 1 = data write, 0 = read |
| bus_ifetch | input | 1 | Read is an instruction fetch |
| bus_addr | input | AW | Transfer address |
| bus_data | input | DW | Fetched word or write data |
| status | output | UPW+4 | {address field, end, control-flow error, data error, watchdog} |

## Verification
The hardest situation to reach is a second control-flow identifier write that arrives while the divider is still busy. The result must come from the first operand pair only. The bench issues an exact pair and, one cycle later, an inexact one, then expects a clean status. A near-exhaustive sweep of block identifiers 0 to 12 against a set of products and non-multiples checks the remainder rule arithmetically. Pseudo-random fetch sequences of varying length, with a junk fetch placed before the clear marker, drive both passing compares and single-bit-flipped compares.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;
  localparam int ST_WDOG = 0;
  localparam int ST_DATA = 1;
  localparam int ST_FLOW = 2;
  localparam int ST_END  = 3;
  localparam int ST_ADDR = 4;
  localparam int ST_FIXED = 4;
endpackage

// File: rtl/cfsig_sigtrack.sv
module cfsig_sigtrack #(
  parameter int DW = 16,
  parameter int OPW = 6,
  parameter int unsigned RST_OP = 'h3A,
  parameter int unsigned CHK_OP = 'h3B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch,
  input  logic [DW-1:0] fdata,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          chk_fail
);
  logic [DW-1:0]  sig_q;
  logic [DW-1:0]  ref_q;
  logic           armed_q;
  logic [OPW-1:0] opc;

  assign opc = fdata[DW-1 -: OPW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q   <= '0;
      ref_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (fetch) begin
        if (opc == OPW'(RST_OP)) begin
          sig_q <= '0;
        end else if (opc == OPW'(CHK_OP)) begin
          ref_q   <= sig_q;
          armed_q <= 1'b1;
        end else begin
          sig_q <= sig_q ^ fdata;
        end
      end
      if (wr && armed_q) armed_q <= 1'b0;
    end
  end

  assign chk_fail = armed_q && wr && (wdata != ref_q);
endmodule

// File: rtl/cfsig_divider.sv
module cfsig_divider #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rem,
  output logic [DW-1:0] dsr_out,
  output logic          dsr_zero
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dvd_q;
  logic [DW-1:0] dsr_q;
  logic [DW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic [DW-1:0] rem_nx;

  always_comb begin
    trial  = {rem_q, dvd_q[DW-1]};
    diff   = trial - {1'b0, dsr_q};
    rem_nx = (trial >= {1'b0, dsr_q}) ? diff[DW-1:0] : trial[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q <= '0;
      dsr_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        dvd_q <= dividend;
        dsr_q <= divisor;
        rem_q <= '0;
        cnt_q <= CW'(DW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_nx;
        dvd_q <= {dvd_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign rem      = rem_q;
  assign dsr_out  = dsr_q;
  assign dsr_zero = (dsr_q == '0);
endmodule

// File: rtl/cfsig_watchdog.sv
module cfsig_watchdog #(
  parameter int AW = 10,
  parameter int unsigned LIMIT = 2000,
  parameter int unsigned USED_LIMIT = 768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          acc,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          expired;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (run && expired) || (acc && (addr >= AW'(USED_LIMIT)));
endmodule

// File: rtl/cfsig_monitor.sv
module cfsig_monitor #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int UPW = 9,
  parameter int OPW = 6,
  parameter int unsigned RST_OP = 'h3A,
  parameter int unsigned CHK_OP = 'h3B,
  parameter int unsigned WDT_LIMIT = 2000,
  parameter int unsigned USED_LIMIT = 'h300,
  parameter int unsigned SWERR_ADDR = 'h2F0,
  parameter int unsigned BID_ADDR = 'h2F4,
  parameter int unsigned CFID_ADDR = 'h2F8,
  parameter int unsigned END_ADDR = 'h2FC
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_valid,
  input  logic                            bus_write,
  input  logic                            bus_ifetch,
  input  logic [AW-1:0]                   bus_addr,
  input  logic [DW-1:0]                   bus_data,
  output logic [UPW+cfsig_pkg::ST_FIXED-1:0] status
);
  import cfsig_pkg::*;

  logic           fetch, dwr, rd_acc;
  logic           done_q, wd_q, dat_q, cf_q;
  logic [UPW-1:0] up_q;
  logic [AW-1:0]  last_fetch_q;
  logic [DW-1:0]  bid_q;
  logic           chk_fail, wd_hit, sw_err, end_hit;
  logic           div_start, div_busy, div_done, div_zero, div_fail;
  logic [DW-1:0]  div_rem, div_bid;
  logic           any_err;

  assign fetch   = bus_valid && !bus_write && bus_ifetch;
  assign dwr     = bus_valid && bus_write;
  assign rd_acc  = bus_valid;
  assign sw_err  = dwr && (bus_addr == AW'(SWERR_ADDR));
  assign end_hit = dwr && (bus_addr == AW'(END_ADDR));
  assign div_start = dwr && (bus_addr == AW'(CFID_ADDR)) && !done_q;

  cfsig_sigtrack #(.DW(DW), .OPW(OPW), .RST_OP(RST_OP), .CHK_OP(CHK_OP)) u_sig (
    .clk(clk), .rst(rst), .fetch(fetch), .fdata(bus_data),
    .wr(dwr), .wdata(bus_data), .chk_fail(chk_fail)
  );

  cfsig_divider #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .dividend(bus_data), .divisor(bid_q),
    .busy(div_busy), .done(div_done), .rem(div_rem), .dsr_out(div_bid),
    .dsr_zero(div_zero)
  );

  cfsig_watchdog #(.AW(AW), .LIMIT(WDT_LIMIT), .USED_LIMIT(USED_LIMIT)) u_wdg (
    .clk(clk), .rst(rst), .run(!done_q), .acc(rd_acc), .addr(bus_addr), .hit(wd_hit)
  );

  assign div_fail = div_done && ((div_rem != '0) || div_zero);
  assign any_err  = wd_hit || sw_err || chk_fail || div_fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      bid_q        <= '0;
      last_fetch_q <= '0;
    end else begin
      if (dwr && (bus_addr == AW'(BID_ADDR))) bid_q <= bus_data;
      if (fetch) last_fetch_q <= bus_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      wd_q   <= 1'b0;
      dat_q  <= 1'b0;
      cf_q   <= 1'b0;
      up_q   <= '0;
    end else if (!done_q) begin
      wd_q  <= wd_hit;
      dat_q <= sw_err;
      cf_q  <= chk_fail || div_fail;
      if (any_err) begin
        done_q <= 1'b1;
        up_q   <= last_fetch_q[UPW-1:0];
      end else if (end_hit) begin
        done_q <= 1'b1;
        up_q   <= '1;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_WDOG] = wd_q;
    status[ST_DATA] = dat_q;
    status[ST_FLOW] = cf_q;
    status[ST_END]  = done_q;
    status[UPW+ST_ADDR-1:ST_ADDR] = up_q;
  end
  // R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 are realised above and in the submodules
endmodule

// File: rtl/cfsig_monitor_chk.sv
module cfsig_monitor_chk #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int UPW = 9,
  parameter int unsigned USED_LIMIT = 'h300,
  parameter int unsigned SWERR_ADDR = 'h2F0
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [UPW+3:0]   status,
  input logic             div_done,
  input logic [DW-1:0]    div_rem,
  input logic [DW-1:0]    div_bid,
  input logic             div_zero
);
  logic done, anyerr;
  logic [UPW-1:0] upf;
  assign done   = status[3];
  assign anyerr = |status[2:0];
  assign upf    = status[UPW+3:4];

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(status));
  assert_err_closes_R10: assert property (@(posedge clk) disable iff (rst)
    anyerr |-> done);
  assert_clean_ones_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !anyerr) |-> (upf == '1));
  assert_open_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> (upf == '0));
  assert_rem_range_R5: assert property (@(posedge clk) disable iff (rst)
    (div_done && !div_zero) |-> (div_rem < div_bid));
  assert_unused_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && (bus_addr >= AW'(USED_LIMIT)) && !done) |=> status[0]);
  assert_swerr_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && (bus_addr == AW'(SWERR_ADDR)) && !done) |=> status[1]);
endmodule

bind cfsig_monitor cfsig_monitor_chk #(
  .AW(AW), .DW(DW), .UPW(UPW), .USED_LIMIT(USED_LIMIT), .SWERR_ADDR(SWERR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .status(status), .div_done(div_done), .div_rem(div_rem),
  .div_bid(div_bid), .div_zero(div_zero)
);

// File: tb/tb_cfsig_monitor.sv
`timescale 1ns/1ps
module tb_cfsig_monitor;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int UPW = 9;
  localparam int LIM = 300;
  localparam logic [AW-1:0] A_SWERR = 10'h2F0;
  localparam logic [AW-1:0] A_BID   = 10'h2F4;
  localparam logic [AW-1:0] A_CFID  = 10'h2F8;
  localparam logic [AW-1:0] A_END   = 10'h2FC;
  localparam logic [DW-1:0] W_RST   = 16'hE800;
  localparam logic [DW-1:0] W_CHK   = 16'hEC00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_ifetch = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic [UPW+3:0] status;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfsig_monitor #(.AW(AW), .DW(DW), .UPW(UPW), .WDT_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_ifetch(bus_ifetch), .bus_addr(bus_addr), .bus_data(bus_data), .status(status)
  );

  task automatic check(input string req, input logic [UPW+3:0] got, input logic [UPW+3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 1'b0; bus_write = 1'b0; bus_ifetch = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_ifetch = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_ifetch = 1'b0; bus_addr = a; bus_data = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_valid = 1'b1; bus_write = 1'b0; bus_ifetch = 1'b0; bus_addr = a; bus_data = '0;
    @(negedge clk); idle();
  endtask

  function automatic logic [DW-1:0] step(input logic [DW-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [DW-1:0] plain(input logic [DW-1:0] w);
    logic [DW-1:0] v = w;
    if (v[15:10] == 6'h3A || v[15:10] == 6'h3B) v[15] = 1'b0;
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 reset", status, '0);

    // R2 R3 R4: signature sweep, pass and single-bit-flip fail
    for (int t = 0; t < 24; t++) begin
      logic [DW-1:0] lf, sig, w;
      int n;
      logic [AW-1:0] chk_a;
      do_reset();
      lf = 16'h1 + 16'(t * 97);
      sig = '0;
      n = 1 + (t % 7);
      fetch(10'h030, 16'h1234 ^ 16'(t));          // R3: discarded by clear marker
      fetch(10'h040, W_RST);
      for (int i = 0; i < n; i++) begin
        lf = step(lf);
        w = plain(lf);
        sig ^= w;
        fetch(10'h041 + 10'(i), w);
      end
      chk_a = 10'h041 + 10'(n);
      fetch(chk_a, W_CHK);                          // R4: marker not accumulated
      if (t % 2 == 0) begin
        wr(10'h100, sig);
        check("R2 compare pass", status, '0);
        wr(A_END, 16'h0);
        check("R11 clean end", status, {9'h1FF, 4'b1000});
      end else begin
        wr(10'h100, sig ^ (16'h1 << (t % 16)));
        check("R2 compare mismatch", status, {chk_a[8:0], 4'b1100});
      end
    end

    // R5: division sweep
    for (int b = 0; b < 13; b++) begin
      for (int k = 0; k < 8; k++) begin
        logic [DW-1:0] cv;
        logic bad;
        case (k)
          0: cv = 16'd0;    1: cv = 16'd30;   2: cv = 16'd77;   3: cv = 16'd210;
          4: cv = 16'd1001; 5: cv = 16'd1155; 6: cv = 16'hFFFF; default: cv = 16'd37;
        endcase
        bad = (b == 0) ? 1'b1 : ((int'(cv) % b) != 0);
        do_reset();
        wr(A_BID, 16'(b));
        wr(A_CFID, cv);
        repeat (DW + 1) @(negedge clk);
        check("R5 remainder rule", status, bad ? 13'h000C : 13'h0000);
      end
    end

    // R6: second CFID write during busy is ignored
    do_reset();
    wr(A_BID, 16'd5);
    wr(A_CFID, 16'd15);
    wr(A_CFID, 16'd16);
    repeat (DW + 2) @(negedge clk);
    check("R6 busy write ignored", status, '0);
    do_reset();
    wr(A_BID, 16'd5);
    wr(A_CFID, 16'd16);
    wr(A_CFID, 16'd15);
    repeat (DW + 2) @(negedge clk);
    check("R6 first operands kept", status, 13'h000C);

    // R9: software data error, address field = last fetch
    do_reset();
    fetch(10'h155, 16'h0101);
    fetch(10'h1A6, 16'h0202);
    wr(A_SWERR, 16'h0);
    check("R9 sw error", status, {9'h1A6, 4'b1010});

    // R8: unused address fetch and read
    do_reset();
    fetch(10'h123, 16'h0001);
    fetch(10'h3F0, 16'h0002);
    check("R8 unused fetch", status, {9'h123, 4'b1001});
    do_reset();
    rd(10'h300);
    check("R8 unused read", status, {9'h000, 4'b1001});
    do_reset();
    rd(10'h2FF);
    check("R8 last used address", status, '0);

    // R10: frozen after end
    do_reset();
    wr(A_END, 16'h0);
    wr(A_SWERR, 16'h0);
    rd(10'h3FF);
    check("R10 frozen after end", status, {9'h1FF, 4'b1000});

    // R7: run-time watchdog
    do_reset();
    repeat (LIM - 1) @(negedge clk);
    check("R7 before limit", status, '0);
    @(negedge clk);
    check("R7 at limit", status, 13'h0009);
    repeat (3) @(negedge clk);
    check("R10 watchdog frozen", status, 13'h0009);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule